// File: doc/BRIEF.md
# Line REI Error Event Counter

This block totals the line-level remote error indications that a far-end receiver reports back in the transport overhead of an STS-1 or STS-3 signal. Once per frame an upstream overhead extractor presents the overhead byte that carries the indication, together with a one-clock strobe. The block adds to a saturating error count. In per-bit mode the amount added is the error value itself. In per-frame mode the block adds one for each frame that reports any error at all.

Software reads the count over a byte-wide register port. The count is split into byte registers at consecutive addresses, starting with the most significant byte. Reading the most significant byte does two things in the same cycle: it freezes the whole count in a holding register and it restarts the live counter from zero. Reads of the remaining bytes return the frozen copy, so a multi-byte read is coherent and no error that arrives during the read is lost.

Top module: `rei_line_counter`

## Requirements
- R1: After synchronous reset, the live count and the holding register are zero, and every byte register reads 0x00.
- R2: With `mode_sel`=0 (per-bit) and `rate_sel`=0 (STS-1), each strobed frame adds bits 3:0 of `oh_byte`; bits 7:4 are ignored.
- R3: With `mode_sel`=0 and `rate_sel`=1 (STS-3), each strobed frame adds the full 8-bit value of `oh_byte`.
- R4: With `mode_sel`=1 (per-frame), a strobed frame adds exactly one when its error value is non-zero and adds nothing otherwise. The error value is bits 3:0 at STS-1 and all 8 bits at STS-3.
- R5: When `frame_stb` is low, `oh_byte` has no effect and the count holds.
- R6: `rd_data` is registered and is valid the cycle after `rd_en`. Offset k from `BASE_ADDR` is byte k counted from the most significant end, so the default map is 0x0218 for bits 31:24 through 0x021B for bits 7:0. Any other address reads 0x00 and changes nothing.
- R7: A read at `BASE_ADDR` returns the top byte of the live count, copies the whole live count into the holding register and clears the live count, all in that cycle.
- R8: A read at any other mapped offset returns that byte of the holding register and leaves both the live count and the holding register unchanged.
- R9: If a strobed frame arrives in the same cycle as a clearing read, that frame's increment becomes the new live count.
- R10: The count saturates at all ones and never wraps.
- R11: A change of `mode_sel` or `rate_sel` does not alter the count and applies from the next strobed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | Qualifies `oh_byte` for one clock per frame |
| oh_byte | input | 8 | Overhead byte carrying the remote error value |
| rate_sel | input | 1 | 0 = STS-1 (low nibble), 1 = STS-3 (full byte) |
| mode_sel | input | 1 | 0 = add the error value, 1 = add one per errored frame |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |

## Verification
The bench builds the counter with `CNT_W`=16, which gives two byte registers at 0x0218 and 0x0219. At that width a few hundred full-byte STS-3 frames reach saturation, so the R10 ceiling can be checked in a short run, while the same generate logic maps and snapshots the bytes. Random frames with random mode and rate settings are mixed with directed cases: STS-1 frames whose upper nibble alone is set, a read that coincides with a frame, unmapped reads, and mode changes between reads.

// File: rtl/rei_cnt_pkg.sv
package rei_cnt_pkg;

    localparam int OH_W   = 8;
    localparam int NIB_W  = 4;

    typedef enum logic {
        RATE_STS1 = 1'b0,
        RATE_STS3 = 1'b1
    } rate_e;

    typedef enum logic {
        ACC_PER_BIT   = 1'b0,
        ACC_PER_FRAME = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic            valid;
        logic [OH_W-1:0] amount;
    } incr_t;

    // Error value carried in the overhead byte for the selected rate.
    function automatic logic [OH_W-1:0] error_value(rate_e rate, logic [OH_W-1:0] b);
        logic [OH_W-1:0] v;
        if (rate == RATE_STS3) v = b;
        else                   v = {{(OH_W-NIB_W){1'b0}}, b[NIB_W-1:0]};
        return v;
    endfunction

    // Amount to add for one frame under the selected mode.
    function automatic logic [OH_W-1:0] frame_amount(acc_mode_e mode, logic [OH_W-1:0] ev);
        logic [OH_W-1:0] a;
        if (mode == ACC_PER_FRAME) a = (ev != '0) ? OH_W'(1) : '0;
        else                       a = ev;
        return a;
    endfunction

endpackage

// File: rtl/rei_incr_decode.sv
module rei_incr_decode
    import rei_cnt_pkg::*;
(
    input  logic              frame_stb,
    input  logic [OH_W-1:0]   oh_byte,
    input  rate_e             rate,
    input  acc_mode_e         mode,
    output incr_t             incr
);
    logic [OH_W-1:0] ev;

    always_comb begin
        ev          = error_value(rate, oh_byte);
        incr.valid  = frame_stb;
        incr.amount = frame_stb ? frame_amount(mode, ev) : '0;
    end
endmodule

// File: rtl/rei_sat_accum.sv
module rei_sat_accum
    import rei_cnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  incr_t            incr,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        // A clearing read restarts from zero; a same-cycle frame still lands.
        base = clr ? '0 : cnt_q;
        sum  = {1'b0, base} + {{(CNT_W+1-OH_W){1'b0}}, incr.amount};
        if (!incr.valid)   nxt = base;
        else if (sum[CNT_W]) nxt = CNT_MAX;
        else               nxt = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end
endmodule

// File: rtl/rei_read_port.sv
module rei_read_port #(
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0218
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic              clr,
    output logic [CNT_W-1:0]  hold_q,
    output logic [7:0]        rd_data
);
    localparam int NUM_BYTES = CNT_W / 8;

    logic [ADDR_W-1:0] offs;
    logic [7:0]        lane_live [NUM_BYTES];
    logic [7:0]        lane_hold [NUM_BYTES];
    logic [7:0]        sel;

    // Lane k is byte k counted from the most significant end.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        assign lane_live[k] = live_cnt[CNT_W-1-8*k -: 8];
        assign lane_hold[k] = hold_q[CNT_W-1-8*k -: 8];
    end

    always_comb begin
        offs = rd_addr - BASE_ADDR;
        clr  = rd_en && (offs == '0);
        sel  = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (offs == ADDR_W'(k)) sel = (k == 0) ? lane_live[k] : lane_hold[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            rd_data <= '0;
        end else begin
            if (clr)   hold_q  <= live_cnt;
            if (rd_en) rd_data <= sel;
        end
    end
endmodule

// File: rtl/rei_line_counter.sv
module rei_line_counter
    import rei_cnt_pkg::*;
#(
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0218
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [7:0]        oh_byte,
    input  logic              rate_sel,
    input  logic              mode_sel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    incr_t            incr;
    logic             clr;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] hold_cnt;

    rei_incr_decode u_dec (
        .frame_stb (frame_stb),
        .oh_byte   (oh_byte),
        .rate      (rate_e'(rate_sel)),
        .mode      (acc_mode_e'(mode_sel)),
        .incr      (incr)
    );

    rei_sat_accum #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .incr  (incr),
        .clr   (clr),
        .cnt_q (live_cnt)
    );

    rei_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .live_cnt (live_cnt),
        .clr      (clr),
        .hold_q   (hold_cnt),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/rei_line_counter_chk.sv
module rei_line_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_stb,
    input logic             clr,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] hold_cnt,
    input logic [7:0]       rd_data
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (live_cnt == '0 && hold_cnt == '0 && rd_data == 8'h00));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !clr) |=> $stable(live_cnt));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !frame_stb) |=> (live_cnt == '0));

    assert_snapshot_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hold_cnt == $past(live_cnt)));

    assert_hold_kept_R8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $stable(hold_cnt));

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (live_cnt >= $past(live_cnt)));

    assert_max_sticks_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr && (&live_cnt)) |=> (&live_cnt));
endmodule

bind rei_line_counter rei_line_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .clr       (clr),
    .live_cnt  (live_cnt),
    .hold_cnt  (hold_cnt),
    .rd_data   (rd_data)
);

// File: tb/tb_rei_line_counter.sv
module tb_rei_line_counter;
    localparam int          CNT_W = 16;
    localparam int          AW    = 16;
    localparam logic [15:0] BASE  = 16'h0218;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 1'b0;
    logic [7:0] oh_byte = 8'h00;
    logic rate_sel = 1'b0;
    logic mode_sel = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [CNT_W-1:0] model = '0;
    logic [CNT_W-1:0] held  = '0;

    always #10 clk = ~clk;   // 50 MHz

    rei_line_counter #(.CNT_W(CNT_W), .ADDR_W(AW), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .oh_byte(oh_byte),
        .rate_sel(rate_sel), .mode_sel(mode_sel), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_incr(logic [7:0] b, bit r, bit m);
        logic [7:0] v;
        v = r ? b : {4'h0, b[3:0]};
        if (m) return (v != 8'h00) ? 8'h01 : 8'h00;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] exp_add(logic [CNT_W-1:0] c, logic [7:0] a);
        int unsigned s;
        s = int'(c) + int'(a);
        if (s > (2**CNT_W - 1)) return {CNT_W{1'b1}};
        return CNT_W'(s);
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic frame(logic [7:0] b, bit r, bit m);
        @(negedge clk);
        frame_stb = 1'b1; oh_byte = b; rate_sel = r; mode_sel = m;
        @(negedge clk);
        frame_stb = 1'b0; oh_byte = $urandom;
        model = exp_add(model, exp_incr(b, r, m));
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = $urandom;
        d = rd_data;
    endtask

    // Clearing read of the top byte, then the low byte from the hold copy.
    task automatic read_all(string req);
        logic [7:0] d;
        rd(BASE, d);
        check8(req, d, model[CNT_W-1 -: 8]);
        held = model; model = '0;
        rd(BASE + 16'd1, d);
        check8(req, d, held[7:0]);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(BASE + 16'd1, d); check8("R1", d, 8'h00);
        rd(BASE, d);         check8("R1", d, 8'h00);

        // R2: STS-1 per-bit, upper nibble ignored
        frame(8'hF3, 1'b0, 1'b0);
        frame(8'h2C, 1'b0, 1'b0);
        read_all("R2");

        // R3: STS-3 per-bit full byte
        frame(8'hF3, 1'b1, 1'b0);
        frame(8'h80, 1'b1, 1'b0);
        read_all("R3");

        // R4: per-frame, upper-nibble-only STS-1 frame does not count
        frame(8'hF0, 1'b0, 1'b1);
        frame(8'h09, 1'b0, 1'b1);
        frame(8'hF0, 1'b1, 1'b1);
        frame(8'h00, 1'b1, 1'b1);
        read_all("R4");

        // R5: oh_byte toggling without strobe has no effect
        frame(8'h05, 1'b1, 1'b0);
        repeat (5) begin
            @(negedge clk); oh_byte = 8'hFF;
        end
        read_all("R5");

        // R6: unmapped addresses read zero and do not clear
        frame(8'h11, 1'b1, 1'b0);
        rd(BASE - 16'd1, d); check8("R6", d, 8'h00);
        rd(BASE + 16'd2, d); check8("R6", d, 8'h00);
        read_all("R6");

        // R8: low-byte re-read returns hold copy and does not clear live count
        frame(8'h21, 1'b1, 1'b0);
        read_all("R7");
        frame(8'h07, 1'b1, 1'b0);
        rd(BASE + 16'd1, d); check8("R8", d, held[7:0]);
        read_all("R8");

        // R9: frame coincident with clearing read
        frame(8'h40, 1'b1, 1'b0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = BASE; frame_stb = 1'b1; oh_byte = 8'h33;
        rate_sel = 1'b1; mode_sel = 1'b0;
        @(negedge clk);
        rd_en = 1'b0; frame_stb = 1'b0;
        check8("R9", rd_data, model[CNT_W-1 -: 8]);
        model = CNT_W'(8'h33);
        read_all("R9");

        // R11: mode and rate change between frames keeps the count
        frame(8'h0A, 1'b0, 1'b0);
        @(negedge clk); mode_sel = 1'b1; rate_sel = 1'b1;
        repeat (3) @(negedge clk);
        frame(8'hC0, 1'b1, 1'b1);
        read_all("R11");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] b;
            b = $urandom;
            frame(b, 1'($urandom), 1'($urandom));
            if (($urandom % 23) == 0) read_all("R2/R3/R4 random");
        end
        read_all("R6 random");

        // R10: saturation at all ones
        for (int i = 0; i < 300; i++) frame(8'hFF, 1'b1, 1'b0);
        frame(8'hFF, 1'b1, 1'b1);
        read_all("R10");
        check8("R10", held[7:0], 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule